// File: doc/BRIEF.md
# Serial video timing reference detector

This block sits after descrambling in a serial digital video receiver. It takes one recovered bit per serial clock, least significant bit of each word first, and frames the stream into 10-bit parallel words. It compares a three-word sliding window against the timing reference lead-in (all-ones word, then two all-zeros words) at every bit offset. When the lead-in appears at an offset other than the current one, it moves the word boundary so that the next word lines up with the new position.

The parallel word bus runs two word periods behind the serial window. Because of this delay, the all-ones lead word of each reference is on the bus in the same word period in which the reference is flagged. Three active-low flags are registered alongside the words:
- A timing reference flag covers the four words of each reference.
- An end-of-active-video flag marks the fourth word in component mode.
- A new-sync-position flag reports that the last reference moved the framing.

The mode input picks component decoding (1) or composite decoding (0).

Top module: `vtr_detector`

## Requirements
- R1: Bits are taken least significant first. Once locked, at each word boundary the bus `par_word` loads the oldest of the three most recently completed words, so it shows each word two word periods after that word has fully arrived.
- R2: `word_stb` is low for the first 5 serial cycles after each word boundary and high for the last 5, so its rising edge falls mid-word.
- R3: The lead-in 3FF, 000, 000 is matched at every bit offset. On a match, the bit just received ends a word: the bus shows 3FF in the same cycle and the next boundary follows 10 bits later.
- R4: `trs_n` goes low on the boundary where a reference is matched and stays low for exactly four word periods (40 serial cycles).
- R5: In component mode (`comp_mode`=1), `eav_n` goes low for exactly one word period, during the fourth word of a reference, when bit 6 of that fourth word is 1.
- R6: In composite mode (`comp_mode`=0), `eav_n` stays high.
- R7: On each match, `nsp_n` goes low if the match moved the word boundary and goes high if the boundary was already at that position. The framing position after reset counts as the previous position.
- R8: After synchronous reset, `trs_n`, `eav_n` and `nsp_n` are high, `par_word` is zero, `word_stb` is low, and the first word boundary falls on the 10th bit after reset.
- R9: Until the first reference is matched, `par_word` stays zero.
- R10: Timing references are flagged on `trs_n` in composite mode as well as in component mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Descrambled serial data bit |
| comp_mode | input | 1 | 1 = component decoding, 0 = composite |
| par_word | output | 10 | Framed parallel word |
| word_stb | output | 1 | Parallel word strobe, rising mid-word |
| trs_n | output | 1 | Timing reference present, active low |
| eav_n | output | 1 | End of active video, active low |
| nsp_n | output | 1 | New sync position, active low |

## Verification
The assertions check four things on every cycle:
- the bus holds steady while the strobe is high;
- each fall of the reference flag coincides with 3FF on the bus;
- the end-of-video flag is low only inside a reference, and only after a component-mode cycle;
- the bit counter steps by one or restarts at a match.

Three behaviours are shown only by the bench scenarios:
- the exact 40-cycle and 10-cycle pulse lengths;
- realignment after pad bits that shift the offset;
- the difference between moved and unmoved references on the new-sync flag.

The bench's reference model covers these, together with the silence of the end-of-video flag in composite mode.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
    // number of words that make up the searched lead-in
    localparam int LEAD_WORDS = 3;

    typedef enum logic {
        MODE_COMPOSITE = 1'b0,
        MODE_COMPONENT = 1'b1
    } vid_mode_e;
endpackage

// File: rtl/vtr_window.sv
module vtr_window #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [WORD_W-1:0] old_word,
    output logic              hit
);
    localparam int WIN_W = vtr_pkg::LEAD_WORDS * WORD_W;

    logic [WIN_W-1:0] win_d, win_q;
    logic [WIN_W-1:0] lead_pat;

    // lead-in pattern: lowest word all ones, the remaining words all zeros
    always_comb begin
        lead_pat = '0;
        for (int i = 0; i < WORD_W; i++) begin
            lead_pat[i] = 1'b1;
        end
    end

    // newest bit enters at the top; the oldest word sits in the low bits
    always_comb begin
        win_d    = {ser_in, win_q[WIN_W-1:1]};
        hit      = (win_d == lead_pat);
        old_word = win_d[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    // R3: every received bit lands at the top of the search window
    a_r3_bit_enters: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> win_q[WIN_W-1] == $past(ser_in));

    // R3: a match needs a zero as the most recent bit
    a_r3_hit_on_zero: assert property (@(posedge clk) disable iff (rst)
        hit |-> !ser_in);
endmodule

// File: rtl/vtr_framer.sv
module vtr_framer #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [WORD_W-1:0] old_word,
    output logic              word_tick,
    output logic              aligned,
    output logic [WORD_W-1:0] word_q,
    output logic              stb_q
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              locked;
        logic              stb;
        logic [WORD_W-1:0] word;
    } frm_t;

    frm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        aligned   = (s_q.cnt == LAST);
        word_tick = (aligned || hit) && (s_q.locked || hit);
        if (hit || aligned) s_d.cnt = '0;
        else                s_d.cnt = s_q.cnt + 1'b1;
        if (hit) s_d.locked = 1'b1;
        if (word_tick) s_d.word = old_word;
        s_d.stb = (s_d.cnt >= HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign word_q = s_q.word;
    assign stb_q  = s_q.stb;

    // R3: the bit counter steps by one, or restarts when a word ends or the lead-in is matched
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s_q.cnt == '0) || (s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R9: without a lock the parallel bus is still zero
    a_r9_zero_unlocked: assert property (@(posedge clk) disable iff (rst)
        !s_q.locked |-> s_q.word == '0);

    // R2: strobe rises exactly at mid-word
    a_r2_stb_mid: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.stb) |-> s_q.cnt == HALF);
endmodule

// File: rtl/vtr_flags.sv
module vtr_flags #(
    parameter int TRS_WORDS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic word_tick,
    input  logic hit,
    input  logic aligned,
    input  logic comp_mode,
    input  logic fourth_mark,
    output logic trs_n_q,
    output logic eav_n_q,
    output logic nsp_n_q
);
    localparam int LEFT_W = (TRS_WORDS > 2) ? $clog2(TRS_WORDS) : 1;

    typedef struct packed {
        logic [LEFT_W-1:0] left;
        logic              trs_n;
        logic              eav_n;
        logic              nsp_n;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (hit) f_d.nsp_n = aligned;
        if (word_tick) begin
            if (hit) begin
                f_d.left  = LEFT_W'(TRS_WORDS - 1);
                f_d.trs_n = 1'b0;
                f_d.eav_n = 1'b1;
            end else if (f_q.left != '0) begin
                f_d.trs_n = 1'b0;
                f_d.eav_n = !((comp_mode == vtr_pkg::MODE_COMPONENT) &&
                              (f_q.left == LEFT_W'(1)) && fourth_mark);
                f_d.left  = f_q.left - 1'b1;
            end else begin
                f_d.trs_n = 1'b1;
                f_d.eav_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '{left: '0, trs_n: 1'b1, eav_n: 1'b1, nsp_n: 1'b1};
        else     f_q <= f_d;
    end

    assign trs_n_q = f_q.trs_n;
    assign eav_n_q = f_q.eav_n;
    assign nsp_n_q = f_q.nsp_n;

    // R5: the end-of-video flag lies inside a reference pulse
    a_r5_eav_in_trs: assert property (@(posedge clk) disable iff (rst)
        !f_q.eav_n |-> !f_q.trs_n);

    // R5: the end-of-video flag falls only on the last reference word
    a_r5_eav_last_word: assert property (@(posedge clk) disable iff (rst)
        $fell(f_q.eav_n) |-> f_q.left == '0);

    // R6: the end-of-video flag falls only after a component-mode cycle
    a_r6_no_composite_eav: assert property (@(posedge clk) disable iff (rst)
        $fell(f_q.eav_n) |-> $past(comp_mode));

    // R4: no reference words remain once the flag is released
    a_r4_idle_released: assert property (@(posedge clk) disable iff (rst)
        f_q.trs_n |-> f_q.left == '0);
endmodule

// File: rtl/vtr_detector.sv
module vtr_detector #(
    parameter int WORD_W    = 10,
    parameter int TRS_WORDS = 4,
    parameter int MARK_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              comp_mode,
    output logic [WORD_W-1:0] par_word,
    output logic              word_stb,
    output logic              trs_n,
    output logic              eav_n,
    output logic              nsp_n
);
    logic [WORD_W-1:0] old_word;
    logic              hit;
    logic              word_tick;
    logic              aligned;

    vtr_window #(.WORD_W(WORD_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .old_word (old_word),
        .hit      (hit)
    );

    vtr_framer #(.WORD_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .old_word  (old_word),
        .word_tick (word_tick),
        .aligned   (aligned),
        .word_q    (par_word),
        .stb_q     (word_stb)
    );

    vtr_flags #(.TRS_WORDS(TRS_WORDS)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .word_tick   (word_tick),
        .hit         (hit),
        .aligned     (aligned),
        .comp_mode   (comp_mode),
        .fourth_mark (old_word[MARK_BIT]),
        .trs_n_q     (trs_n),
        .eav_n_q     (eav_n),
        .nsp_n_q     (nsp_n)
    );

    // R4: a reference pulse starts with the all-ones lead word on the bus
    a_r4_starts_on_lead: assert property (@(posedge clk) disable iff (rst)
        $fell(trs_n) |-> par_word == '1);

    // R7: the new-sync flag falls only together with a matched lead-in
    a_r7_nsp_on_ref: assert property (@(posedge clk) disable iff (rst)
        $fell(nsp_n) |-> (!trs_n && par_word == '1));

    // R1: the bus holds steady while the strobe is high
    a_r1_word_steady: assert property (@(posedge clk) disable iff (rst)
        (word_stb && $past(word_stb)) |-> $stable(par_word));
endmodule

// File: tb/vtr_detector_test.sv
module vtr_detector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       comp_mode = 1'b1;
    logic [9:0] par_word;
    logic       word_stb, trs_n, eav_n, nsp_n;

    int checks = 0;
    int errs = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vtr_detector uut (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .comp_mode (comp_mode),
        .par_word  (par_word),
        .word_stb  (word_stb),
        .trs_n     (trs_n),
        .eav_n     (eav_n),
        .nsp_n     (nsp_n)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: queue of received bits, counters as integers
    bit         bq[$];
    int         pos_m;
    bit         lock_m;
    logic [9:0] word_m;
    bit         stb_m, trs_m, eav_m, nsp_m;
    int         left_m;

    function automatic logic [9:0] word_at(int k);
        logic [9:0] r;
        for (int j = 0; j < 10; j++) r[j] = bq[10*k + j];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            bq.delete();
            pos_m = 0; lock_m = 0; word_m = '0;
            stb_m = 0; trs_m = 1; eav_m = 1; nsp_m = 1; left_m = 0;
        end else begin
            bit found, edge_here;
            bq.push_back(ser_in);
            if (bq.size() > 30) void'(bq.pop_front());
            found = (bq.size() == 30) && word_at(0) == 10'h3FF &&
                    word_at(1) == 10'h000 && word_at(2) == 10'h000;
            edge_here = (pos_m == 9);
            if (found) begin
                nsp_m = edge_here;
                lock_m = 1;
            end
            if ((found || edge_here) && lock_m) begin
                word_m = word_at(0);
                if (found) begin
                    trs_m = 0; eav_m = 1; left_m = 3;
                end else if (left_m > 0) begin
                    trs_m = 0;
                    eav_m = !(comp_mode && left_m == 1 && word_m[6]);
                    left_m--;
                end else begin
                    trs_m = 1; eav_m = 1;
                end
            end
            pos_m = (found || edge_here) ? 0 : pos_m + 1;
            stb_m = (pos_m >= 5);
        end
    end

    int trs_low = 0;
    int eav_low = 0;

    always @(negedge clk) begin
        if (run && !rst) begin
            chk(lock_m ? "R1 word" : "R9 word", par_word, word_m);
            chk("R2 strobe", word_stb, stb_m);
            chk(comp_mode ? "R4 trs" : "R10 trs", trs_n, trs_m);
            chk(comp_mode ? "R5 eav" : "R6 eav", eav_n, eav_m);
            chk("R7 nsp", nsp_n, nsp_m);
            if (!trs_n) trs_low++;
            if (!eav_n) eav_low++;
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk);
        ser_in = b;
    endtask

    task automatic send_word(logic [9:0] w);
        for (int j = 0; j < 10; j++) send_bit(w[j]);
    endtask

    task automatic send_data(int n);
        for (int i = 0; i < n; i++) send_word(10'h200 | 10'($urandom & 32'h1FF));
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset values, checked while reset is held
        chk("R8 word", par_word, 0);
        chk("R8 strobe", word_stb, 0);
        chk("R8 trs", trs_n, 1);
        chk("R8 eav", eav_n, 1);
        chk("R8 nsp", nsp_n, 1);
        rst = 1'b0;
        run = 1'b1;

        // pre-lock traffic: the bus must stay zero (R9)
        send_data(4);
        settle();
        chk("R9 unlocked word", par_word, 0);

        // component reference at a shifted offset, fourth word marks end of video
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        trs_low = 0; eav_low = 0;
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
        settle();
        chk("R3 lead on bus", par_word, 10'h3FF);
        chk("R7 moved", nsp_n, 0);
        send_word(10'h274);
        send_data(6);
        chk("R4 pulse length", trs_low, 40);
        chk("R5 pulse length", eav_low, 10);

        // same offset, start-of-video fourth word
        trs_low = 0; eav_low = 0;
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
        settle();
        chk("R7 unmoved", nsp_n, 1);
        send_word(10'h200);
        send_data(6);
        chk("R5 no mark", eav_low, 0);
        chk("R4 pulse length 2", trs_low, 40);

        // same offset, end of video again
        eav_low = 0;
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000); send_word(10'h2C4);
        send_data(5);
        chk("R5 pulse length 2", eav_low, 10);

        // composite mode, shifted by 4 bits
        comp_mode = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        trs_low = 0; eav_low = 0;
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
        settle();
        chk("R7 moved composite", nsp_n, 0);
        chk("R3 lead composite", par_word, 10'h3FF);
        send_word(10'h000);
        send_data(6);
        // fourth word with bit 6 set must still leave the end-of-video flag high
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000); send_word(10'h240);
        send_data(6);
        chk("R10 composite pulses", trs_low, 80);
        chk("R6 composite eav", eav_low, 0);
        settle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end
endmodule